// File: doc/BRIEF.md
# Bounded Memory Stack Pointer Unit

This block owns the pointer of a small last-in, first-out store kept in an external single-port synchronous memory. The store grows toward lower addresses. A client raises a push or a pop request. The unit checks the pointer against two fixed boundary addresses before it touches the memory. It then issues at most one memory access and, one cycle later, reports a done pulse with a pass/fail status and, for a pop, the data read.

On a push, the pointer is decremented and the data is written to the new top address. On a pop, the entry at the current top is read and the pointer is then incremented. A request that would run past either boundary, or that asks for a push and a pop together, is refused. A refused request causes no memory access and leaves the pointer as it was. The unit handles one request at a time. Requests seen during the response cycle are dropped.

Top module: `lifo_ptr_ctrl`

## Requirements
- R1: After reset the pointer holds the empty address (0x4000 by default), `rsp_done` is low and `mem_en` is low.
- R2: An accepted push drives `mem_en`=1, `mem_we`=1, `mem_addr` = pointer minus one and `mem_wdata` = `req_wdata` in the request cycle. The pointer then takes that address.
- R3: An accepted pop drives `mem_en`=1, `mem_we`=0 and `mem_addr` = pointer in the request cycle. The pointer then moves up by one. The read word appears on `rsp_rdata` together with `rsp_done` in the following cycle.
- R4: A pop while the pointer equals the empty address fails and causes no memory access in its request cycle.
- R5: A push while the pointer equals the empty address minus DEPTH (0x3FFB by default) fails and causes no memory access. The store therefore holds DEPTH entries, from 0x3FFF down to 0x3FFB.
- R6: `rsp_done` pulses for exactly one cycle, on the cycle after the request. `rsp_fail` in that cycle is 0 for success and 1 for failure.
- R7: A failed request leaves the pointer unchanged, so the next accepted access uses the same address it would have used without the failed request.
- R8: A push and a pop raised in the same cycle fail together and cause no memory access.
- R9: A request present during the response cycle is ignored. It produces no memory access and no further response.
- R10: Pops return the pushed words in reverse order of pushing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_push | input | 1 | Push request |
| req_pop | input | 1 | Pop request |
| req_wdata | input | DATA_W | Word to push |
| rsp_rdata | output | DATA_W | Word read by a successful pop, zero otherwise |
| rsp_fail | output | 1 | Status: 0 success, 1 failure; valid with rsp_done |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the access |

## Verification
The bench builds the unit with its defaults: 16-bit addresses and data, an empty address of 0x4000 and a depth of five. With only five entries, both boundaries can be reached within a handful of requests. This lets the bench fill the store, bounce off the full limit, drain it past the empty limit and check the pointer through later access addresses after each refusal. It also holds a request across the response cycle, so the rule that drops requests in that cycle is exercised.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PUSH = 2'd1,
    PH_POP  = 2'd2,
    PH_FAIL = 2'd3
  } phase_e;

  localparam logic STAT_OK   = 1'b0;
  localparam logic STAT_FAIL = 1'b1;
endpackage

// File: rtl/lifo_bound_chk.sv
module lifo_bound_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] EMPTY_ADDR = 16'h4000,
  parameter int DEPTH = 5
) (
  input  logic [ADDR_W-1:0] sp,
  input  logic              want_push,
  input  logic              want_pop,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              reject
);
  localparam logic [ADDR_W-1:0] FULL_ADDR = EMPTY_ADDR - ADDR_W'(DEPTH);

  function automatic logic at_full(input logic [ADDR_W-1:0] p);
    return p == FULL_ADDR;
  endfunction

  function automatic logic at_empty(input logic [ADDR_W-1:0] p);
    return p == EMPTY_ADDR;
  endfunction

  logic clash;
  assign clash   = want_push & want_pop;
  assign push_ok = want_push & ~clash & ~at_full(sp);
  assign pop_ok  = want_pop  & ~clash & ~at_empty(sp);
  assign reject  = (want_push | want_pop) & ~push_ok & ~pop_ok;
endmodule

// File: rtl/lifo_sp_reg.sv
module lifo_sp_reg #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] EMPTY_ADDR = 16'h4000,
  parameter int DEPTH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec,
  input  logic              inc,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] sp_down
);
  localparam logic [ADDR_W-1:0] FULL_ADDR = EMPTY_ADDR - ADDR_W'(DEPTH);

  function automatic logic [ADDR_W-1:0] ptr_down(input logic [ADDR_W-1:0] p);
    return p - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] ptr_up(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction

  assign sp_down = ptr_down(sp);

  always_ff @(posedge clk) begin
    if (!rst_n)   sp <= EMPTY_ADDR;
    else if (dec) sp <= ptr_down(sp);
    else if (inc) sp <= ptr_up(sp);
  end

  // Pointer must stay inside the region between the two limits.
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sp >= FULL_ADDR);
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= EMPTY_ADDR);
endmodule

// File: rtl/lifo_resp_fsm.sv
module lifo_resp_fsm
  import lifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push_ok,
  input  logic pop_ok,
  input  logic reject,
  output logic idle,
  output logic rsp_done,
  output logic rsp_fail,
  output logic sel_rd
);
  phase_e phase_q, phase_d;

  assign idle = (phase_q == PH_IDLE);

  always_comb begin
    phase_d = PH_IDLE;
    if (idle) begin
      if (push_ok)     phase_d = PH_PUSH;
      else if (pop_ok) phase_d = PH_POP;
      else if (reject) phase_d = PH_FAIL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign rsp_done = ~idle;
  assign rsp_fail = (phase_q == PH_FAIL) ? STAT_FAIL : STAT_OK;
  assign sel_rd   = (phase_q == PH_POP);

  // A response lasts a single cycle.
  assert_one_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

// File: rtl/lifo_ptr_ctrl.sv
module lifo_ptr_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] EMPTY_ADDR = 16'h4000,
  parameter int DEPTH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_push,
  input  logic              req_pop,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_fail,
  output logic              rsp_done,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              idle;
  logic              want_push, want_pop;
  logic              push_ok, pop_ok, reject;
  logic              sel_rd;
  logic [ADDR_W-1:0] sp_q, sp_dn;

  // Requests only count while no response is pending.
  assign want_push = req_push & idle;
  assign want_pop  = req_pop  & idle;

  lifo_bound_chk #(.ADDR_W(ADDR_W), .EMPTY_ADDR(EMPTY_ADDR), .DEPTH(DEPTH)) u_chk (
    .sp(sp_q), .want_push(want_push), .want_pop(want_pop),
    .push_ok(push_ok), .pop_ok(pop_ok), .reject(reject)
  );

  lifo_sp_reg #(.ADDR_W(ADDR_W), .EMPTY_ADDR(EMPTY_ADDR), .DEPTH(DEPTH)) u_sp (
    .clk(clk), .rst_n(rst_n), .dec(push_ok), .inc(pop_ok),
    .sp(sp_q), .sp_down(sp_dn)
  );

  lifo_resp_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .pop_ok(pop_ok),
    .reject(reject), .idle(idle), .rsp_done(rsp_done),
    .rsp_fail(rsp_fail), .sel_rd(sel_rd)
  );

  assign mem_en    = push_ok | pop_ok;
  assign mem_we    = push_ok;
  assign mem_addr  = push_ok ? sp_dn : sp_q;
  assign mem_wdata = req_wdata;
  assign rsp_rdata = sel_rd ? mem_rdata : '0;

  assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !mem_en);
  assert_fail_noaccess_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fail) |-> !$past(mem_en));
  assert_fail_keeps_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fail) |-> (sp_q == $past(sp_q)));
  assert_push_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> (sp_q == $past(mem_addr)));
  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (sp_q == $past(mem_addr) + ADDR_W'(1)));
endmodule

// File: tb/lifo_ptr_ctrl_bench.sv
`timescale 1ns/1ps
module lifo_ptr_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_push = 1'b0, req_pop = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rsp_rdata, mem_addr, mem_wdata, mem_rdata;
  logic        rsp_fail, rsp_done, mem_en, mem_we;

  always #2.5 clk = ~clk;

  lifo_ptr_ctrl u_lifo_ptr_ctrl (
    .clk(clk), .rst_n(rst_n), .req_push(req_push), .req_pop(req_pop),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_fail(rsp_fail),
    .rsp_done(rsp_done), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Memory model: one-cycle read latency.
  logic [15:0] mem [8];
  always_ff @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[2:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[2:0]];
    end
  end

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  typedef struct { bit fail; bit is_pop; logic [15:0] data; } exp_t;
  exp_t exp_q[$];
  int msp = 'h4000;
  logic [15:0] mstk[$];

  // Monitor: compares each response against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_fail == e.fail, "R6 status", rsp_fail, e.fail);
        if (e.is_pop && !e.fail)
          chk(rsp_rdata == e.data, "R3/R10 pop data", rsp_rdata, e.data);
      end
    end
  end

  // Driver: issues one request, checks the memory port and queues the outcome.
  task automatic issue(input bit p, input bit q, input logic [15:0] d, input bit hold);
    exp_t e;
    bit ok;
    @(negedge clk);
    req_push = p; req_pop = q; req_wdata = d;
    #0.5;
    ok = p ? (!q && msp != 'h3FFB) : (q && msp != 'h4000);
    e.fail = !ok; e.is_pop = q && !p; e.data = '0;
    chk(mem_en == ok, "R4/R5/R8 access enable", mem_en, ok);
    if (ok && p) begin
      chk(mem_we && mem_addr == 16'(msp - 1), "R2 push address", mem_addr, msp - 1);
      chk(mem_wdata == d, "R2 push data", mem_wdata, d);
      msp = msp - 1; mstk.push_back(d);
    end else if (ok) begin
      chk(!mem_we && mem_addr == 16'(msp), "R3 pop address", mem_addr, msp);
      e.data = mstk.pop_back();
      msp = msp + 1;
    end
    exp_q.push_back(e);
    @(negedge clk);
    if (hold) begin
      #0.5;
      chk(mem_en == 1'b0, "R9 request ignored while busy", mem_en, 0);
    end
    req_push = 0; req_pop = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk(rsp_done == 0, "R1 done low after reset", rsp_done, 0);
    chk(mem_en == 0, "R1 no access after reset", mem_en, 0);
    issue(0, 1, 16'h0, 0);                // R4 pop on empty
    for (int i = 0; i < 5; i++) issue(1, 0, 16'hA100 + 16'(i), 0); // R2, R5 fill
    issue(1, 0, 16'hDEAD, 0);             // R5 push on full
    issue(0, 1, 16'h0, 0);                // R10 last in first out
    issue(1, 1, 16'hBEEF, 0);             // R8 both together
    issue(1, 0, 16'h5A5A, 1);             // R7 pointer kept, R9 hold
    issue(0, 1, 16'h0, 1);                // R9 hold on pop
    for (int i = 0; i < 5; i++) issue(0, 1, 16'h0, 0);  // drain, R4 at end
    issue(1, 0, 16'h1234, 0);             // R1/R7 address back to top
    issue(0, 1, 16'h0, 0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 every request answered", exp_q.size(), 0);
    report();
  end
endmodule